// File: doc/BRIEF.md
# Chop-Cycle Winding Current Controller

This block regulates the current in a single motor winding by running a fixed-length chop cycle and choosing, cycle by cycle, how the four switches of the H-bridge are driven. It counts a programmable number of clocks per chop cycle. That setting selects the chop frequency: at a 50 MHz clock, 1000 clocks gives 50 kHz and 250 clocks gives 200 kHz. Every cycle opens by driving current into the winding. The opening eighth of the cycle always drives, whatever the current-sense comparator shows. After that opening, the block watches the comparator to decide whether the current was still rising toward the target, or whether it had already overshot and must be pulled down hard. The closing eighth of every cycle always uses fast decay.

The comparator bit, the enable and the target polarity come from the surrounding control logic. The block returns its present regulation state and the four switch enables. Any change in the requested switch state passes through a gap in which every switch is off, so that no bridge leg conducts from supply to ground. Dropping the enable opens all switches and parks the sequencer at the start of a cycle.

Top module: `chop_decay_ctrl`

## Requirements
- R1: While reset is high, and on the cycle after it is released, `mode_o` reads 0 (idle) and all four switch enables are 0.
- R2: The state code is 0 for idle, 1 for drive, 2 for slow decay and 3 for fast decay. A cycle of P clocks has an eighth of E = floor(P/8) clocks. Positions 0 to E-1 of every cycle report drive, whatever `at_ref` shows.
- R3: If the sequencer is still in drive and `at_ref` is sampled high at a position after E and before P-E, the state moves to slow decay and stays there until the closing eighth.
- R4: If `at_ref` is sampled high on the edge that enters position E, the state goes directly from drive to fast decay and stays there for the rest of the cycle.
- R5: Positions P-E to P-1 always report fast decay. This applies whether the cycle got there from drive or from slow decay.
- R6: A cycle lasts exactly P clocks and then restarts at position 0 in drive. P is taken from `period_i` only when a new cycle starts. Any setting below 16 is treated as 16.
- R7: The switch enables are listed as {hs_a, ls_a, hs_b, ls_b}. With `pol` = 1, drive sets 1001, fast decay sets 0110 and slow decay sets 0101. With `pol` = 0, drive sets 0110, fast decay sets 1001 and slow decay sets 0101. Idle sets 0000.
- R8: Any change of the state or of `pol` holds all four switches off for DEAD_CLKS (2) cycles, counted from the last change, before the new pattern appears.
- R9: While `en` is low, the state is idle and all switches are off. The first enabled edge starts a new cycle at position 0 in drive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulation enable |
| pol | input | 1 | Target current polarity (1: current from side A to side B) |
| period_i | input | CNT_W (12) | Chop cycle length in clocks |
| at_ref | input | 1 | Comparator: winding current at or above the reference |
| mode_o | output | 2 | Present state: 0 idle, 1 drive, 2 slow decay, 3 fast decay |
| hs_a | output | 1 | High-side switch enable, side A |
| ls_a | output | 1 | Low-side switch enable, side A |
| hs_b | output | 1 | High-side switch enable, side B |
| ls_b | output | 1 | Low-side switch enable, side B |

## Verification
If the position counter or the latched cycle length is wrong, `mode_o` shows it within one cycle. Either fast decay begins at the wrong position, or drive restarts on the wrong clock. If the state register takes a wrong branch after the forced-drive window, the error appears on `mode_o` on the very next clock as slow instead of fast decay, or the reverse. If the applied-pattern register or the gap counter is wrong, the error reaches the switch pins within DEAD_CLKS+1 clocks of a state change, as a missing gap or a wrong diagonal. A clock-by-clock reference model of the cycle rules therefore flags any divergence at most a few clocks after it arises.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        MD_IDLE   = 2'd0,
        MD_CHARGE = 2'd1,
        MD_SLOW   = 2'd2,
        MD_FAST   = 2'd3
    } chop_mode_e;

    typedef struct packed {
        logic hs_a;
        logic ls_a;
        logic hs_b;
        logic ls_b;
    } gate_t;

    localparam gate_t GATES_OFF = '{hs_a: 1'b0, ls_a: 1'b0, hs_b: 1'b0, ls_b: 1'b0};

    // Switch pattern for a regulation state and a target polarity.
    function automatic gate_t drive_pattern(input chop_mode_e m, input logic p);
        gate_t g;
        g = GATES_OFF;
        case (m)
            MD_CHARGE: begin
                g.hs_a = p;
                g.ls_b = p;
                g.hs_b = !p;
                g.ls_a = !p;
            end
            MD_FAST: begin
                g.hs_a = !p;
                g.ls_b = !p;
                g.hs_b = p;
                g.ls_a = p;
            end
            MD_SLOW: begin
                g.ls_a = 1'b1;
                g.ls_b = 1'b1;
            end
            default: g = GATES_OFF;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/chop_seq.sv
module chop_seq
    import chop_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int MIN_PERIOD = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] period_i,
    input  logic             at_ref,
    output chop_mode_e       mode_o
);

    localparam logic [CNT_W-1:0] MIN_P = CNT_W'(MIN_PERIOD);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] per_in;
    logic [CNT_W-1:0] eighth;
    logic [CNT_W-1:0] tail_start;
    logic [CNT_W-1:0] cnt_nxt;
    logic             last_pos;
    chop_mode_e       mode_q;
    chop_mode_e       mode_nxt;

    assign per_in     = (period_i < MIN_P) ? MIN_P : period_i;
    assign eighth     = per_q >> 3;
    assign tail_start = per_q - eighth;
    assign cnt_nxt    = cnt_q + 1'b1;
    assign last_pos   = (cnt_q == per_q - 1'b1);

    // State reached at the next position inside the current cycle.
    always_comb begin
        mode_nxt = mode_q;
        if (cnt_nxt >= tail_start) begin
            mode_nxt = MD_FAST;
        end else begin
            case (mode_q)
                MD_CHARGE: begin
                    if (cnt_nxt >= eighth && at_ref)
                        mode_nxt = (cnt_nxt == eighth) ? MD_FAST : MD_SLOW;
                    else
                        mode_nxt = MD_CHARGE;
                end
                MD_SLOW: mode_nxt = MD_SLOW;
                MD_FAST: mode_nxt = MD_FAST;
                default: mode_nxt = MD_CHARGE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            per_q  <= MIN_P;
            mode_q <= MD_IDLE;
        end else if (!en) begin
            cnt_q  <= '0;
            mode_q <= MD_IDLE;
        end else if (mode_q == MD_IDLE || last_pos) begin
            cnt_q  <= '0;
            per_q  <= per_in;
            mode_q <= MD_CHARGE;
        end else begin
            cnt_q  <= cnt_nxt;
            mode_q <= mode_nxt;
        end
    end

    assign mode_o = mode_q;

    // R2: the opening eighth of a cycle is always drive.
    a_r2_forced_charge: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MD_IDLE && cnt_q < eighth) |-> (mode_q == MD_CHARGE));

    // R5: the closing eighth of a cycle is always fast decay.
    a_r5_fast_tail: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MD_IDLE && cnt_q >= tail_start) |-> (mode_q == MD_FAST));

    // R6: the last position wraps back to position zero.
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (mode_q != MD_IDLE && last_pos) |=> (cnt_q == '0));

    // R9: a low enable parks the sequencer.
    a_r9_park: assert property (@(posedge clk) disable iff (rst)
        !en |=> (mode_q == MD_IDLE && cnt_q == '0));

endmodule

// File: rtl/chop_bridge.sv
module chop_bridge
    import chop_pkg::*;
#(
    parameter int DEAD_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  chop_mode_e mode_i,
    input  logic       pol_i,
    output gate_t      gate_o
);

    generate
        if (DEAD_CLKS == 0) begin : g_direct
            assign gate_o = drive_pattern(mode_i, pol_i);
        end else begin : g_gap
            localparam int DW = $clog2(DEAD_CLKS + 1);

            chop_mode_e    cur_mode;
            logic          cur_pol;
            logic [DW-1:0] gap_q;
            logic          req_change;

            assign req_change = (mode_i != cur_mode) || (pol_i != cur_pol);

            always_ff @(posedge clk) begin
                if (rst) begin
                    cur_mode <= MD_IDLE;
                    cur_pol  <= 1'b0;
                    gap_q    <= '0;
                end else if (req_change) begin
                    cur_mode <= mode_i;
                    cur_pol  <= pol_i;
                    gap_q    <= DW'(DEAD_CLKS);
                end else if (gap_q != '0) begin
                    gap_q <= gap_q - 1'b1;
                end
            end

            assign gate_o = (gap_q != '0) ? GATES_OFF : drive_pattern(cur_mode, cur_pol);

            // R8: a new request is followed by switches off.
            a_r8_gap_after_request: assert property (@(posedge clk) disable iff (rst)
                req_change |=> (gate_o == GATES_OFF));
        end
    endgenerate

    // R7: no leg ever has both of its switches on.
    a_r7_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
        !(gate_o.hs_a && gate_o.ls_a) && !(gate_o.hs_b && gate_o.ls_b));

endmodule

// File: rtl/chop_decay_ctrl.sv
module chop_decay_ctrl
    import chop_pkg::*;
#(
    parameter int CNT_W      = 12,
    parameter int MIN_PERIOD = 16,
    parameter int DEAD_CLKS  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             pol,
    input  logic [CNT_W-1:0] period_i,
    input  logic             at_ref,
    output logic [1:0]       mode_o,
    output logic             hs_a,
    output logic             ls_a,
    output logic             hs_b,
    output logic             ls_b
);

    chop_mode_e mode_q;
    gate_t      gates;

    chop_seq #(
        .CNT_W      (CNT_W),
        .MIN_PERIOD (MIN_PERIOD)
    ) seq_i (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .period_i (period_i),
        .at_ref   (at_ref),
        .mode_o   (mode_q)
    );

    chop_bridge #(
        .DEAD_CLKS (DEAD_CLKS)
    ) bridge_i (
        .clk    (clk),
        .rst    (rst),
        .mode_i (mode_q),
        .pol_i  (pol),
        .gate_o (gates)
    );

    assign mode_o = mode_q;
    assign hs_a   = gates.hs_a;
    assign ls_a   = gates.ls_a;
    assign hs_b   = gates.hs_b;
    assign ls_b   = gates.ls_b;

    // R8: a change of reported state reaches the pins as an all-off gap.
    a_r8_dead_gap: assert property (@(posedge clk) disable iff (rst)
        (mode_o != $past(mode_o)) |=> (!hs_a && !ls_a && !hs_b && !ls_b));

endmodule

// File: tb/chop_decay_ctrl_tb.sv
module chop_decay_ctrl_tb_top;

    localparam int CNT_W = 12;
    localparam int DEAD  = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             en = 1'b0;
    logic             pol = 1'b1;
    logic [CNT_W-1:0] period_i = 12'd40;
    logic             at_ref = 1'b0;
    logic [1:0]       mode_o;
    logic             hs_a, ls_a, hs_b, ls_b;

    int checks = 0;
    int errors = 0;

    // Comparator stimulus: 0 always low, 1 always high, 2 high from position ref_thr on.
    int ref_mode = 0;
    int ref_thr  = 0;

    always #10 clk = !clk;

    chop_decay_ctrl #(.CNT_W(CNT_W), .MIN_PERIOD(16), .DEAD_CLKS(DEAD)) dut_i (
        .clk(clk), .rst(rst), .en(en), .pol(pol), .period_i(period_i),
        .at_ref(at_ref), .mode_o(mode_o),
        .hs_a(hs_a), .ls_a(ls_a), .hs_b(hs_b), .ls_b(ls_b)
    );

    // Reference model, written from the requirements.
    int   m_cnt = 0, m_per = 16, m_mode = 0, m_cur_mode = 0, m_gap = 0;
    logic m_cur_pol = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 0; m_per = 16; m_mode = 0;
            m_cur_mode = 0; m_cur_pol = 1'b0; m_gap = 0;
        end else begin
            if (m_mode != m_cur_mode || pol != m_cur_pol) begin
                m_cur_mode = m_mode; m_cur_pol = pol; m_gap = DEAD;
            end else if (m_gap > 0) begin
                m_gap = m_gap - 1;
            end
            if (!en) begin
                m_cnt = 0; m_mode = 0;
            end else if (m_mode == 0 || m_cnt == m_per - 1) begin
                m_cnt = 0; m_mode = 1;
                m_per = (int'(period_i) < 16) ? 16 : int'(period_i);
            end else begin
                m_cnt = m_cnt + 1;
                if (m_cnt >= m_per - m_per / 8) m_mode = 3;
                else if (m_mode == 1 && m_cnt >= m_per / 8 && at_ref)
                    m_mode = (m_cnt == m_per / 8) ? 3 : 2;
            end
        end
    end

    function automatic logic [3:0] exp_gates(int md, logic p, int gap);
        if (gap > 0) return 4'b0000;
        case (md)
            1: return p ? 4'b1001 : 4'b0110;
            3: return p ? 4'b0110 : 4'b1001;
            2: return 4'b0101;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic string mode_tag();
        if (!en) return "R9";
        if (m_mode == 1 && m_cnt < m_per / 8) return "R2";
        if (m_mode == 3 && m_cnt >= m_per - m_per / 8) return "R5";
        if (m_mode == 3) return "R4";
        if (m_mode == 2) return "R3";
        return "R6";
    endfunction

    // Comparator driver.
    always begin
        @(posedge clk);
        #3;
        case (ref_mode)
            1: at_ref = 1'b1;
            2: at_ref = (m_cnt >= ref_thr);
            default: at_ref = 1'b0;
        endcase
    end

    // Clock-by-clock comparison, away from the active edge.
    always @(negedge clk) begin
        logic [3:0] g, eg;
        g  = {hs_a, ls_a, hs_b, ls_b};
        if (rst) begin
            checks++;
            if (mode_o != 2'd0 || g != 4'b0000) begin
                errors++;
                $display("FAIL R1 reset mode=%0d gates=%b expected mode=0 gates=0000", mode_o, g);
            end
        end else begin
            eg = exp_gates(m_cur_mode, m_cur_pol, m_gap);
            checks++;
            if (int'(mode_o) != m_mode) begin
                errors++;
                $display("FAIL %s mode actual=%0d expected=%0d pos=%0d", mode_tag(), mode_o, m_mode, m_cnt);
            end
            checks++;
            if (g != eg) begin
                errors++;
                $display("FAIL %s gates actual=%b expected=%b",
                         (m_gap > 0) ? "R8" : (!en ? "R9" : "R7"), g, eg);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #3;
    endtask

    initial begin
        step(5);
        rst = 1'b0;                       // R1: first cycle after release
        step(2);
        // R2/R5: comparator stays low, drive until the closing eighth.
        en = 1'b1; period_i = 12'd40; ref_mode = 0;
        step(90);
        // R4: comparator high at the end of the forced window.
        ref_mode = 1;
        step(90);
        // R3: comparator rises later in drive, slow decay then fast tail.
        period_i = 12'd64; ref_mode = 2; ref_thr = 12;
        step(200);
        // R7: reversed polarity, with a flip in the middle of drive (R8).
        pol = 1'b0;
        step(70);
        ref_mode = 0;
        step(10);
        pol = 1'b1;
        step(1);
        pol = 1'b0;
        step(80);
        // R6: setting below the floor is clamped to 16, change taken at cycle start.
        period_i = 12'd5; ref_mode = 2; ref_thr = 4;
        step(60);
        // R9: enable dropped mid-cycle, then restored.
        step(7);
        en = 1'b0;
        step(12);
        en = 1'b1;
        period_i = 12'd250; ref_thr = 100;
        step(520);
        // R6: 50 kHz setting at the 50 MHz clock.
        period_i = 12'd1000; ref_thr = 300;
        step(1300);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R6 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule